// File: doc/BRIEF.md
# Stereo Sample Gain, Mute and Zero-Run Processor

This block sits between a serial audio receiver and a delta-sigma modulator and conditions each stereo pair of 24-bit two's-complement samples. Each channel is scaled by its own 8-bit attenuation code on a logarithmic law of 0.5 dB per code step, with the lowest code meaning silence. A soft mute slides the effective code down to silence one step per sample, and slides it back up when released. The sign of the output can be inverted, and a converter-off control forces the output to the bipolar zero value (0).

In parallel the block counts bit-clock ticks during which no nonzero sample has arrived. After a parameterised run of ticks, 65536 by default, it raises a zero flag. A separate enable decides whether that flag also forces the output to zero; the flag works either way.

Top module: `smp_gain_proc`

## Requirements
- R1: The effective code c sets the gain. With s = 255 - c, the shift is floor(s/12), the index is k = s mod 12, and the mantissa is round(32768 * 2^(-k/12)). The output is (sample * mantissa) divided by 2^(15 + shift), rounded to nearest with ties toward plus infinity, and saturated to 24 bits. Code FFh therefore passes the sample through unchanged.
- R2: An effective code of 00h gives an output of exactly 0 for any input.
- R3: After reset both effective codes are FFh. The target code is 00h while mute_req is high and the channel's programmed code otherwise. Each accepted sample is processed with the effective code as it stood before that sample, and the code then moves one step toward the target.
- R4: When invert is high, the scaled value is negated. -2^23 saturates to 2^23-1.
- R5: While dac_off is high at a clock edge, both outputs become 0 at that edge, whatever the input.
- R6: zero_flag rises once ZERO_RUN bit_tick cycles have been counted since the last accepted sample that was nonzero in either channel. Such a sample clears the count and the flag at the edge that accepts it.
- R7: With zd_force_en high and zero_flag high, both outputs become 0 at the next edge. With zd_force_en low, the flag has no effect on the outputs.
- R8: out_valid is in_valid delayed by one cycle. The outputs are registered, and they hold their value in cycles with no sample and no forcing.
- R9: During and right after reset, out_valid, zero_flag and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair present |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| bit_tick | input | 1 | One pulse per bit-clock cycle |
| atten_left | input | 8 | Programmed left attenuation code |
| atten_right | input | 8 | Programmed right attenuation code |
| mute_req | input | 1 | Soft mute request |
| dac_off | input | 1 | Force the output to bipolar zero |
| invert | input | 1 | Negate the output phase |
| zd_force_en | input | 1 | Let the zero flag force the output |
| out_valid | output | 1 | Processed pair present |
| out_left | output | 24 | Processed left sample |
| out_right | output | 24 | Processed right sample |
| zero_flag | output | 1 | Long zero run detected |

## Verification
Full-scale positive and negative samples at code FFh with inversion separate the pass-through path from the saturating negation. Long runs of samples while the code ramps through every step up and down exercise all twelve mantissas and every shift, so an error in the table, the shift or the rounding shows up as an exact mismatch. Random samples with random codes, mute toggles and inversion check the lag of the ramp against the programmed code. Two zero runs probe the flag threshold one tick before and at the limit, once with forcing disabled and once enabled, followed by a nonzero sample that must clear the flag.

// File: rtl/smp_pkg.sv
package smp_pkg;
    localparam int MANT_W = 16;
    localparam int FRAC   = 15;

    // 2^(-k/12) scaled by 2^15, rounded
    function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] k);
        logic [MANT_W-1:0] m;
        case (k)
            4'd0:    m = 16'd32768;
            4'd1:    m = 16'd30929;
            4'd2:    m = 16'd29193;
            4'd3:    m = 16'd27554;
            4'd4:    m = 16'd26008;
            4'd5:    m = 16'd24548;
            4'd6:    m = 16'd23170;
            4'd7:    m = 16'd21870;
            4'd8:    m = 16'd20643;
            4'd9:    m = 16'd19484;
            4'd10:   m = 16'd18390;
            4'd11:   m = 16'd17358;
            default: m = 16'd32768;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/chan_gain.sv
module chan_gain
    import smp_pkg::*;
#(
    parameter int DW = 24,
    parameter int CW = 8
) (
    input  logic signed [DW-1:0] smp,
    input  logic        [CW-1:0] code,
    input  logic                 inv,
    output logic signed [DW-1:0] res
);
    localparam int PW = DW + MANT_W + 1;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic signed [PW-1:0] PMAX = PW'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [PW-1:0] PMIN = -PMAX - PW'(1);
    localparam logic signed [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};

    logic        [CW-1:0]     steps;
    logic        [CW-1:0]     shf;
    logic        [3:0]        kidx;
    logic        [MANT_W-1:0] mant;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     rnd;
    logic signed [PW-1:0]     scaled;
    logic signed [DW-1:0]     gained;

    always_comb begin
        steps  = CMAX - code;
        shf    = steps / CW'(12);
        kidx   = 4'(steps % CW'(12));
        mant   = mant_of(kidx);
        prod   = PW'(smp) * PW'($signed({1'b0, mant}));
        rnd    = PW'(1) <<< (int'(shf) + FRAC - 1);
        scaled = (prod + rnd) >>> (int'(shf) + FRAC);
        if (code == '0)          gained = '0;
        else if (scaled > PMAX)  gained = DMAX;
        else if (scaled < PMIN)  gained = DMIN;
        else                     gained = DW'(scaled);
        if (!inv)                res = gained;
        else if (gained == DMIN) res = DMAX;
        else                     res = -gained;
    end
endmodule

// File: rtl/code_ramp.sv
module code_ramp #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] tgt,
    input  logic          adv,
    output logic [CW-1:0] nxt
);
    always_comb begin
        if (!adv)          nxt = cur;
        else if (cur < tgt) nxt = cur + CW'(1);
        else if (cur > tgt) nxt = cur - CW'(1);
        else               nxt = cur;
    end
endmodule

// File: rtl/zero_run_next.sv
module zero_run_next #(
    parameter int LIMIT = 65536,
    parameter int NW    = 17
) (
    input  logic [NW-1:0] cnt,
    input  logic          tick,
    input  logic          clr,
    output logic [NW-1:0] nxt
);
    always_comb begin
        if (clr)                             nxt = '0;
        else if (tick && cnt != NW'(LIMIT))  nxt = cnt + NW'(1);
        else                                 nxt = cnt;
    end
endmodule

// File: rtl/smp_gain_proc.sv
module smp_gain_proc #(
    parameter int DW       = 24,
    parameter int CW       = 8,
    parameter int ZERO_RUN = 65536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_left,
    input  logic [DW-1:0] in_right,
    input  logic          bit_tick,
    input  logic [CW-1:0] atten_left,
    input  logic [CW-1:0] atten_right,
    input  logic          mute_req,
    input  logic          dac_off,
    input  logic          invert,
    input  logic          zd_force_en,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right,
    output logic          zero_flag
);
    localparam int NCH  = 2;
    localparam int CNTW = $clog2(ZERO_RUN + 1);

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] eff;
        logic [CNTW-1:0]        cnt;
        logic                   vld;
        logic [NCH-1:0][DW-1:0] dat;
    } state_t;

    state_t st_d, st_q;

    logic [NCH-1:0][DW-1:0] ch_in;
    logic [NCH-1:0][CW-1:0] ch_code;
    logic [NCH-1:0][CW-1:0] ch_tgt;
    logic [NCH-1:0][CW-1:0] eff_nxt;
    logic [NCH-1:0][DW-1:0] ch_res;
    logic [CNTW-1:0]        cnt_nxt;
    logic                   nonzero;
    logic                   flag_now;
    logic                   force_zero;

    assign ch_in[0]   = in_left;
    assign ch_in[1]   = in_right;
    assign ch_code[0] = atten_left;
    assign ch_code[1] = atten_right;
    assign nonzero    = in_valid && ((|in_left) || (|in_right));
    assign flag_now   = (st_q.cnt == CNTW'(ZERO_RUN));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_tgt[c] = mute_req ? '0 : ch_code[c];

        code_ramp #(.CW(CW)) u_ramp (
            .cur (st_q.eff[c]),
            .tgt (ch_tgt[c]),
            .adv (in_valid),
            .nxt (eff_nxt[c])
        );

        chan_gain #(.DW(DW), .CW(CW)) u_gain (
            .smp  (ch_in[c]),
            .code (st_q.eff[c]),
            .inv  (invert),
            .res  (ch_res[c])
        );
    end

    zero_run_next #(.LIMIT(ZERO_RUN), .NW(CNTW)) u_zrun (
        .cnt  (st_q.cnt),
        .tick (bit_tick),
        .clr  (nonzero),
        .nxt  (cnt_nxt)
    );

    always_comb begin
        force_zero = dac_off || (zd_force_en && flag_now);
        st_d       = st_q;
        st_d.vld   = in_valid;
        st_d.eff   = eff_nxt;
        st_d.cnt   = cnt_nxt;
        for (int c = 0; c < NCH; c++) begin
            if (force_zero)    st_d.dat[c] = '0;
            else if (in_valid) st_d.dat[c] = ch_res[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.eff <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_left  = st_q.dat[0];
    assign out_right = st_q.dat[1];
    assign zero_flag = flag_now;
endmodule

// File: rtl/smp_gain_proc_chk.sv
module smp_gain_proc_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_left,
    input logic [DW-1:0] in_right,
    input logic          dac_off,
    input logic          zd_force_en,
    input logic          out_valid,
    input logic [DW-1:0] out_left,
    input logic [DW-1:0] out_right,
    input logic          zero_flag
);
    logic nz_in;
    assign nz_in = in_valid && ((|in_left) || (|in_right));

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R5
    dac_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_off |=> (out_left == '0 && out_right == '0));
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nz_in |=> !zero_flag);
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_flag && !nz_in) |=> zero_flag);
    // R7
    zd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zd_force_en && zero_flag) |=> (out_left == '0 && out_right == '0));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !dac_off && !(zd_force_en && zero_flag))
        |=> ($stable(out_left) && $stable(out_right)));
endmodule

bind smp_gain_proc smp_gain_proc_chk #(.DW(DW)) u_chk (.*);

// File: tb/smp_gain_proc_tb.sv
module smp_gain_proc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        bit_tick = 1'b0;
    logic [7:0]  atten_left = 8'hFF;
    logic [7:0]  atten_right = 8'hFF;
    logic        mute_req = 1'b0;
    logic        dac_off = 1'b0;
    logic        invert = 1'b0;
    logic        zd_force_en = 1'b0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        zero_flag;

    int checks = 0;
    int errors = 0;
    logic [7:0] effm [2];

    always #2 clk = ~clk;

    smp_gain_proc u_dut (.*);

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic longint mant_ref(input int k);
        return longint'($floor(32768.0 * $pow(2.0, -k / 12.0) + 0.5));
    endfunction

    function automatic longint clamp24(input longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic logic [23:0] exp_gain(input logic [23:0] s, input logic [7:0] c, input bit inv);
        longint p;
        int st, sh;
        if (c == 8'h00) p = 0;
        else begin
            st = 255 - int'(c);
            sh = st / 12;
            p  = longint'($signed(s)) * mant_ref(st % 12);
            p  = clamp24((p + (64'sd1 <<< (14 + sh))) >>> (15 + sh));
        end
        if (inv) p = clamp24(-p);
        return p[23:0];
    endfunction

    function automatic logic [7:0] step_to(input logic [7:0] cur, input logic [7:0] tgt);
        if (cur < tgt) return cur + 8'd1;
        if (cur > tgt) return cur - 8'd1;
        return cur;
    endfunction

    task automatic send(input logic [23:0] l, input logic [23:0] r, input string tag);
        logic [23:0] el, er;
        bit frc;
        @(negedge clk);
        in_left = l; in_right = r; in_valid = 1'b1;
        frc = dac_off || (zd_force_en && zero_flag);
        el = frc ? 24'h0 : exp_gain(l, effm[0], invert);
        er = frc ? 24'h0 : exp_gain(r, effm[1], invert);
        effm[0] = step_to(effm[0], mute_req ? 8'h00 : atten_left);
        effm[1] = step_to(effm[1], mute_req ? 8'h00 : atten_right);
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_left, el);
        check(tag, out_right, er);
        check("R8 valid", {23'd0, out_valid}, 24'd1);
    endtask

    task automatic idle(input string tag);
        logic [23:0] hl, hr;
        bit frc;
        @(negedge clk);
        hl = out_left; hr = out_right;
        frc = dac_off || (zd_force_en && zero_flag);
        @(negedge clk);
        check(tag, out_left, frc ? 24'h0 : hl);
        check(tag, out_right, frc ? 24'h0 : hr);
        check("R8 idle valid", {23'd0, out_valid}, 24'd0);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        bit_tick = 1'b1;
        repeat (n) @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1716));
        effm[0] = 8'hFF; effm[1] = 8'hFF;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 out_left", out_left, 24'h0);
        check("R9 out_right", out_right, 24'h0);
        check("R9 valid/flag", {22'd0, out_valid, zero_flag}, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", {22'd0, out_valid, zero_flag}, 24'd0);

        // R1 unity at code FFh
        send(24'h123456, 24'hFEDCBA, "R1 unity");
        check("R1 passthrough", out_left, 24'h123456);
        send(24'h7FFFFF, 24'h800000, "R1 full scale");
        // R4 inversion and saturation
        invert = 1'b1;
        send(24'h800000, 24'h000005, "R4 invert");
        check("R4 saturate", out_left, 24'h7FFFFF);
        check("R4 negate", out_right, 24'hFFFFFB);
        invert = 1'b0;

        // R3 soft mute ramp down then back up
        mute_req = 1'b1;
        for (int i = 0; i < 260; i++) send(24'h400000, 24'hC00001, "R3 mute ramp");
        check("R3 muted", out_left, 24'h0);
        mute_req = 1'b0;
        for (int i = 0; i < 40; i++) send(24'h3A5A5A, 24'hC5A5A5, "R3 release ramp");

        // R2 code 00h gives silence
        atten_left = 8'h00; atten_right = 8'h00;
        for (int i = 0; i < 260; i++) send(24'h7FFFFF, 24'h800000, "R2 ramp to zero code");
        check("R2 silence", out_right, 24'h0);

        // R1 random mix with ramping codes, inversion, mute
        for (int i = 0; i < 400; i++) begin
            if (i % 40 == 0) begin
                atten_left  = 8'($urandom);
                atten_right = 8'($urandom);
            end
            if ($urandom % 23 == 0) mute_req = ~mute_req;
            invert = 1'($urandom);
            send(24'($urandom), 24'($urandom), "R1 random");
        end
        mute_req = 1'b0; invert = 1'b0;

        // R5 converter off with and without a sample
        dac_off = 1'b1;
        send(24'h111111, 24'h222222, "R5 dac_off sample");
        idle("R5 dac_off idle");
        dac_off = 1'b0;
        send(24'h0ABCDE, 24'h0EDCBA, "R5 released");
        idle("R8 hold");
        idle("R8 hold again");

        // R6 zero run, forcing disabled
        zd_force_en = 1'b0;
        send(24'h000001, 24'h0, "R6 clear");
        ticks(65535);
        check("R6 below limit", {23'd0, zero_flag}, 24'd0);
        ticks(1);
        check("R6 at limit", {23'd0, zero_flag}, 24'd1);
        idle("R7 no force idle");
        send(24'h200000, 24'hE00000, "R7 flag without force");
        check("R6 flag cleared", {23'd0, zero_flag}, 24'd0);

        // R7 zero run with forcing
        zd_force_en = 1'b1;
        ticks(65536);
        check("R6 flag again", {23'd0, zero_flag}, 24'd1);
        idle("R7 forced idle");
        check("R7 forced zero", out_left, 24'h0);
        send(24'h300000, 24'hD00000, "R7 forced sample");
        check("R6 clear on nonzero", {23'd0, zero_flag}, 24'd0);
        send(24'h300000, 24'hD00000, "R7 after clear");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule